// File: doc/BRIEF.md
# Reconfigurable Clause Implication Network

This block computes, for every variable of a bounded 3-SAT instance, whether the present partial assignment forces that variable to 1 and whether it forces it to 0. Each variable has one cell built from a fixed template. The template is a sum of products with TERMS product terms on the "forced true" side and TERMS product terms on the "forced false" side. Each product term has two factor slots. A product term stands for one clause that contains the variable: it fires when the other literals of that clause are all false. Because a clause has at most three literals, two factors per term are always enough.

The template never changes. Only the routing changes from one instance to the next. Each factor slot holds a select entry, loaded through an address/data port, that names the source variable and the literal polarity. The slot's valid bit says whether it is in use. The search controllers drive the 2-bit encoded current values of all variables. The block returns the registered implied pairs together with a global contradiction flag and a global change flag, which the controllers use in their next round.

A two-state sequencer governs the block. In LOAD the select table may be written and all outputs are held at zero. In EVAL the table is frozen and the network evaluates every cycle. The only transitions are LOAD→EVAL on `go` and EVAL→LOAD on `halt`.

Top module: `impl_net`

## Requirements
- R1: After reset the sequencer is in LOAD, every output is 0 and every select entry is cleared (valid = 0). A network with no valid entry therefore implies nothing.
- R2: Each variable v takes bits [2v+1:2v] of `vals`. Bit 1 set alone (2'b10) means assigned 1, bit 0 set alone (2'b01) means assigned 0, 2'b00 means unassigned and 2'b11 means conflicting.
- R3: A factor is true only when its source variable holds exactly the code opposite to the literal. A positive literal needs 2'b01 and a negated literal needs 2'b10. The codes 2'b00 and 2'b11 never make a factor true.
- R4: A product term is the AND of its valid factors. A term with no valid factor is 0. The slot address is ((v*2+side)*TERMS+term)*2+k, where side 1 is the forced-true side and side 0 is the forced-false side.
- R5: `imp_true[v]` is the OR of the side-1 terms of variable v, and `imp_false[v]` is the OR of its side-0 terms.
- R6: A select entry is {valid, polarity, index}. The index is in bits [IW-1:0], the polarity is bit IW (1 = plain literal, 0 = negated literal) and valid is bit IW+1. An index of NVAR or more reads as unassigned.
- R7: A table write is accepted only while the sequencer is in LOAD. A write presented in EVAL leaves the table unchanged.
- R8: In LOAD a clock edge with `go` high moves to EVAL. In EVAL a clock edge with `halt` high moves to LOAD. Every edge taken in LOAD drives all outputs to 0.
- R9: Every edge taken in EVAL registers the implications computed from the `vals` present at that edge, so the outputs show them one cycle later.
- R10: At an EVAL edge, `contra` is registered high when any variable has both implications set, has `imp_true` while its value is 2'b01, or has `imp_false` while its value is 2'b10.
- R11: At an EVAL edge, `change` is registered high exactly when the new implied pairs differ from the pairs registered at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Leave LOAD and start evaluating |
| halt | input | 1 | Leave EVAL and return to LOAD |
| cfg_we | input | 1 | Select table write strobe |
| cfg_addr | input | AW (6) | Factor slot address |
| cfg_data | input | EW (5) | Select entry {valid, polarity, index} |
| vals | input | 2*NVAR (16) | Encoded current values of all variables |
| imp_true | output | NVAR (8) | Variable forced to 1 |
| imp_false | output | NVAR (8) | Variable forced to 0 |
| contra | output | 1 | Global contradiction flag |
| change | output | 1 | Global change flag |

## Verification
The bench targets the two codes that must never satisfy a factor: unassigned and conflicting. A design that tested only one bit of the code would fire terms from variables that are still open or in conflict. It checks that a term with no valid slot stays 0, that a term with a single factor works as a two-literal clause, and that polarity is decoded the right way round; an error in any of these would flip implications across the whole instance. It also writes to the table while the network is evaluating and then checks the outputs, so a design that let such writes land would show a changed implication. Random tables and random values under repeated patterns check `change` against the previous pairs and `contra` against the opposing-assignment rule, which catches a design that keys change off `vals` or that misses one of the contradiction sources.

// File: rtl/implnet_pkg.sv
package implnet_pkg;

    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_EVAL = 1'b1
    } net_state_t;

    localparam logic [1:0] CODE_ONE  = 2'b10;
    localparam logic [1:0] CODE_ZERO = 2'b01;

    // Literal is false when its variable holds exactly the opposite code.
    function automatic logic lit_is_false(input logic [1:0] code, input logic plain);
        return plain ? (code == CODE_ZERO) : (code == CODE_ONE);
    endfunction

endpackage

// File: rtl/implnet_cfg.sv
module implnet_cfg #(
    parameter int NSLOT = 64,
    parameter int AW    = 6,
    parameter int EW    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_ok,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [EW-1:0]         data,
    output logic [NSLOT*EW-1:0]   table_flat
);

    logic [NSLOT-1:0][EW-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (we && wr_ok && (int'(addr) < NSLOT)) begin
            sel_q[addr] <= data;
        end
    end

    assign table_flat = sel_q;

    AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(sel_q)); // R7

endmodule

// File: rtl/implnet_cell.sv
module implnet_cell
    import implnet_pkg::*;
#(
    parameter int NVAR  = 8,
    parameter int TERMS = 2,
    parameter int IW    = 3,
    parameter int EW    = 5
) (
    input  logic [2*NVAR-1:0]        vals,
    input  logic [4*TERMS*EW-1:0]    sel,
    output logic                     imp_t,
    output logic                     imp_f
);

    logic [1:0][TERMS-1:0] term;

    for (genvar s = 0; s < 2; s++) begin : g_side
        for (genvar t = 0; t < TERMS; t++) begin : g_term
            logic [1:0] used;
            logic [1:0] holds;
            for (genvar k = 0; k < 2; k++) begin : g_factor
                logic [EW-1:0] ent;
                logic [IW-1:0] idx;
                logic [1:0]    code;
                assign ent  = sel[((s*TERMS+t)*2+k)*EW +: EW];
                assign idx  = ent[IW-1:0];
                assign code = (int'(idx) < NVAR) ? vals[2*idx +: 2] : 2'b00;
                assign used[k]  = ent[IW+1];
                assign holds[k] = !ent[IW+1] || lit_is_false(code, ent[IW]);
            end
            assign term[s][t] = (|used) && (&holds);
        end
    end

    assign imp_t = |term[1];
    assign imp_f = |term[0];

endmodule

// File: rtl/impl_net.sv
module impl_net
    import implnet_pkg::*;
#(
    parameter  int NVAR  = 8,
    parameter  int TERMS = 2,
    localparam int IW    = (NVAR > 1) ? $clog2(NVAR) : 1,
    localparam int EW    = IW + 2,
    localparam int NSLOT = NVAR * 4 * TERMS,
    localparam int AW    = $clog2(NSLOT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                halt,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [EW-1:0]       cfg_data,
    input  logic [2*NVAR-1:0]   vals,
    output logic [NVAR-1:0]     imp_true,
    output logic [NVAR-1:0]     imp_false,
    output logic                contra,
    output logic                change
);

    localparam int CELL_W = 4 * TERMS * EW;

    net_state_t st, st_nx;

    logic [NSLOT*EW-1:0] table_flat;
    logic [NVAR-1:0]     imp_t_n, imp_f_n;
    logic [NVAR-1:0]     imp_t_q, imp_f_q;
    logic                contra_n, contra_q, chg_q;

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_LOAD;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_LOAD: if (go)   st_nx = ST_EVAL;
            ST_EVAL: if (halt) st_nx = ST_LOAD;
        endcase
    end

    implnet_cfg #(.NSLOT(NSLOT), .AW(AW), .EW(EW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (st == ST_LOAD),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .data       (cfg_data),
        .table_flat (table_flat)
    );

    for (genvar v = 0; v < NVAR; v++) begin : g_cell
        implnet_cell #(.NVAR(NVAR), .TERMS(TERMS), .IW(IW), .EW(EW)) u_cell (
            .vals  (vals),
            .sel   (table_flat[v*CELL_W +: CELL_W]),
            .imp_t (imp_t_n[v]),
            .imp_f (imp_f_n[v])
        );
    end

    always_comb begin
        contra_n = 1'b0;
        for (int v = 0; v < NVAR; v++) begin
            if (imp_t_n[v] && imp_f_n[v])                 contra_n = 1'b1;
            if (imp_t_n[v] && vals[2*v +: 2] == CODE_ZERO) contra_n = 1'b1;
            if (imp_f_n[v] && vals[2*v +: 2] == CODE_ONE)  contra_n = 1'b1;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imp_t_q  <= '0;
            imp_f_q  <= '0;
            contra_q <= 1'b0;
            chg_q    <= 1'b0;
        end else begin
            unique case (st)
                ST_EVAL: begin
                    imp_t_q  <= imp_t_n;
                    imp_f_q  <= imp_f_n;
                    contra_q <= contra_n;
                    chg_q    <= (imp_t_n != imp_t_q) || (imp_f_n != imp_f_q);
                end
                ST_LOAD: begin
                    imp_t_q  <= '0;
                    imp_f_q  <= '0;
                    contra_q <= 1'b0;
                    chg_q    <= 1'b0;
                end
            endcase
        end
    end

    assign imp_true  = imp_t_q;
    assign imp_false = imp_f_q;
    assign contra    = contra_q;
    assign change    = chg_q;

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |=> (imp_t_q == '0 && imp_f_q == '0 && !contra_q && !chg_q)); // R8
    AST_BOTH_SIDES_CONTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (|(imp_t_q & imp_f_q)) |-> contra_q); // R10
    AST_CHANGE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |-> (imp_t_q != $past(imp_t_q) || imp_f_q != $past(imp_f_q))); // R11
    AST_STILL_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_EVAL && !chg_q) |-> ($stable(imp_t_q) && $stable(imp_f_q))); // R11

endmodule

// File: tb/sim_impl_net.sv
module sim_impl_net;

    localparam int NV = 8;
    localparam int TM = 2;
    localparam int NS = NV * 4 * TM;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0, halt = 1'b0, cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [4:0]  cfg_data = '0;
    logic [15:0] vals = '0;
    logic [7:0]  imp_true, imp_false;
    logic        contra, change;

    logic [4:0]  shadow [NS];
    logic [7:0]  prev_t, prev_f;
    int          checks = 0, fails = 0;
    int          seed_dummy;

    always #10 clk = ~clk;

    impl_net #(.NVAR(NV), .TERMS(TM)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .halt(halt),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .vals(vals), .imp_true(imp_true), .imp_false(imp_false),
        .contra(contra), .change(change)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic fac_false(input logic [15:0] v, input logic [4:0] e);
        logic [1:0] code;
        code = v[2*int'(e[2:0]) +: 2];
        return e[3] ? (code == 2'b01) : (code == 2'b10);
    endfunction

    function automatic void model(input logic [15:0] v, output logic [7:0] t,
                                  output logic [7:0] f, output logic c);
        t = '0; f = '0; c = 1'b0;
        for (int x = 0; x < NV; x++) begin
            for (int s = 0; s < 2; s++) begin
                for (int tm = 0; tm < TM; tm++) begin
                    logic any, all;
                    any = 1'b0; all = 1'b1;
                    for (int k = 0; k < 2; k++) begin
                        logic [4:0] e;
                        e = shadow[((x*2+s)*TM+tm)*2+k];
                        if (e[4]) begin
                            any = 1'b1;
                            if (!fac_false(v, e)) all = 1'b0;
                        end
                    end
                    if (any && all) begin
                        if (s == 1) t[x] = 1'b1; else f[x] = 1'b1;
                    end
                end
            end
            if (t[x] && f[x]) c = 1'b1;
            if (t[x] && v[2*x +: 2] == 2'b01) c = 1'b1;
            if (f[x] && v[2*x +: 2] == 2'b10) c = 1'b1;
        end
    endfunction

    // Write a select entry; shadow updated only when the table is writable.
    task automatic wr(input int a, input logic [4:0] d, input bit in_load);
        cfg_we = 1'b1; cfg_addr = 6'(a); cfg_data = d;
        if (in_load) shadow[a] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_eval();
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        prev_t = '0; prev_f = '0;
    endtask

    task automatic eval_step(input logic [15:0] v, input string tag);
        logic [7:0] et, ef;
        logic ec;
        vals = v;
        model(v, et, ef, ec);
        @(negedge clk);
        chk({tag, " R5 R9 imp_true"},  32'(imp_true),  32'(et));
        chk({tag, " R5 R9 imp_false"}, 32'(imp_false), 32'(ef));
        chk({tag, " R10 contra"}, 32'(contra), 32'(ec));
        chk({tag, " R11 change"}, 32'(change), 32'((et != prev_t) || (ef != prev_f)));
        prev_t = et; prev_f = ef;
    endtask

    // The halt edge still evaluates; the edge after it is taken in LOAD.
    task automatic stop_eval();
        halt = 1'b1;
        eval_step(vals, "halt-edge");
        halt = 1'b0;
        @(negedge clk);
        chk("R8 outputs cleared in LOAD", {imp_true, imp_false, 14'd0, contra, change}, 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5a7c31);
        for (int i = 0; i < NS; i++) shadow[i] = '0;
        prev_t = '0; prev_f = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {imp_true, imp_false, 14'd0, contra, change}, 32'd0);

        // Cleared table implies nothing, whatever the values (R1, R4)
        start_eval();
        eval_step(16'b01_10_01_10_01_10_01_10, "R1 R4 empty table");
        eval_step(16'hFFFF, "R1 R4 empty table all-conflict");
        chk("R1 no implication from cleared table", 32'(imp_true | imp_false), 32'd0);
        stop_eval();

        // Directed: clause (x0 + x1 + ~x2) on slots 4,5; clause (~x0 + x3) on slot 2
        wr(4, 5'b1_1_001, 1'b1);
        wr(5, 5'b1_0_010, 1'b1);
        wr(2, 5'b1_1_011, 1'b1);
        start_eval();
        // x1=0 (01), x2=1 (10): forces x0 true
        eval_step({8'b00_00_00_00, 2'b00, 2'b10, 2'b01, 2'b00}, "R3 R6 both factors false");
        chk("R4 R6 slot address and polarity", 32'(imp_true[0]), 32'd1);
        // x1 unassigned: no force
        eval_step({8'b0, 2'b00, 2'b10, 2'b00, 2'b00}, "R3 unassigned factor");
        chk("R3 unassigned never satisfies", 32'(imp_true[0]), 32'd0);
        // x1 conflicting: no force
        eval_step({8'b0, 2'b00, 2'b10, 2'b11, 2'b00}, "R3 conflict factor");
        chk("R3 conflict code never satisfies", 32'(imp_true[0]), 32'd0);
        // single-factor term: x3=0 forces x0 false; with x0 assigned 1 -> contra
        eval_step({8'b0, 2'b01, 2'b00, 2'b00, 2'b10}, "R4 single factor");
        chk("R10 implication against assignment", 32'(contra), 32'd1);
        eval_step({8'b0, 2'b01, 2'b10, 2'b01, 2'b00}, "R10 both sides");
        chk("R10 both implications", 32'(contra), 32'd1);
        eval_step({8'b0, 2'b01, 2'b10, 2'b01, 2'b00}, "R11 repeat");
        chk("R11 no change on repeat", 32'(change), 32'd0);

        // Writes during EVAL are ignored (R7): try to clear slots 4 and 2
        wr(4, 5'b0, 1'b0);
        wr(2, 5'b0, 1'b0);
        eval_step({8'b0, 2'b01, 2'b10, 2'b01, 2'b00}, "R7 after EVAL write");
        chk("R7 EVAL write ignored (forced true)",  32'(imp_true[0]),  32'd1);
        chk("R7 EVAL write ignored (forced false)", 32'(imp_false[0]), 32'd1);
        stop_eval();

        // Random tables and values
        for (int r = 0; r < 20; r++) begin
            for (int a = 0; a < NS; a++) begin
                logic [4:0] d;
                d = 5'($urandom);
                d[4] = ($urandom_range(0, 3) != 0);
                wr(a, d, 1'b1);
            end
            start_eval();
            for (int s = 0; s < 30; s++) begin
                logic [15:0] v;
                v = (s % 5 == 4) ? vals : 16'($urandom);
                if (s % 7 == 3) v = v & 16'h5555;
                eval_step(v, "R2 R3 R4 random");
            end
            stop_eval();
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule